// File: doc/BRIEF.md
# Interrupt Request Latch and Mask Bank

This block holds the interrupt state of a small 8-bit controller. Seven maskable sources feed it: two external pins, two timers, an A/D converter, a watchdog timer and a basic interval timer. A one-cycle event pulse from a source sets that source's request flag. The flag stays set until the CPU accepts the source, software writes it to 0, or reset occurs.

Software reaches two enable registers and two request registers over a byte-wide register bus. Each register is split into a high and a low half, and the bits are packed from the MSB. Reads are combinational. Writes take effect at the next clock edge.

The block ANDs each flag with its enable and with a master enable input. From the result it drives a pending request and the index of the highest-priority source that is asserting. When the CPU acknowledges an index, only that source's flag is cleared.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, all flags and enables are 0, and `irq_pending` is 0.
- R2: The enable-high register is at address 0xE2. Bits 7,6,5,4 enable source indices 0,1,2,3 (INT0, INT1, T0, T1). The enable-low register is at 0xE3. Bits 7,6,5 enable indices 4,5,6 (ADC, WDT, BIT). Both registers read back what was written to these bits.
- R3: The request-high register is at 0xE4 and the request-low register is at 0xE5. Their bit positions match the enable registers. Both are readable, and a bus write sets or clears each flag to the written bit value.
- R4: Unimplemented bits read 0 and ignore writes. These are bits 3:0 of 0xE2/0xE4 and bits 4:0 of 0xE3/0xE5. Any other address reads 0x00, and a write to it changes no register.
- R5: A 1 on `src_evt[i]` sets flag i at the next edge. The flag then stays 1 until it is acknowledged, written to 0, or reset.
- R6: `irq_pending` is 1 exactly when `master_en` is 1 and at least one source has both its flag and its enable set.
- R7: `irq_idx` gives the asserting source with the lowest index (INT0=0 highest, BIT=6 lowest), using the encoding of R2.
- R8: An `ack` with `ack_idx` = i clears flag i at the next edge and leaves every other flag unchanged.
- R9: A source event wins over a clear in the same cycle. This holds whether the clear comes from an acknowledge of that source or from a bus write of 0, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| src_evt | input | 7 | Event pulses, bit i = source index i |
| master_en | input | 1 | Master interrupt enable |
| ack | input | 1 | CPU accepts source `ack_idx` |
| ack_idx | input | 3 | Index of the accepted source |
| irq_pending | output | 1 | An enabled request is waiting |
| irq_idx | output | 3 | Index of the winning source |

## Verification
The bench sets every flag and then walks the enable masks down, so each priority level gets a turn to win. An inverted or shifted priority encoder would report the wrong index there. It acknowledges one source while all are set, which exposes an acknowledge that clears a whole register or a neighbouring bit. It drives an event into the same cycle as an acknowledge, and then into the same cycle as a clearing write, to catch a design whose clear beats the set and so loses a request. It also reads unused bits and foreign addresses after writing all-ones, which catches padding bits that store data or address decodes that alias.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter logic [7:0] A_ENH  = 8'hE2,
  parameter logic [7:0] A_ENL  = 8'hE3,
  parameter logic [7:0] A_REQH = 8'hE4,
  parameter logic [7:0] A_REQL = 8'hE5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [6:0] src_evt,
  input  logic       master_en,
  input  logic       ack,
  input  logic [2:0] ack_idx,
  output logic       irq_pending,
  output logic [2:0] irq_idx
);
  localparam int NSRC = 7;

  logic [NSRC-1:0] flag, flag_nxt, en, en_nxt, hit;
  logic            unused_wbits;

  assign unused_wbits = ^bus_wdata[3:0];

  always_comb begin
    en_nxt = en;
    if (bus_we && bus_addr == A_ENH) en_nxt[3:0] = {bus_wdata[4], bus_wdata[5], bus_wdata[6], bus_wdata[7]};
    if (bus_we && bus_addr == A_ENL) en_nxt[6:4] = {bus_wdata[5], bus_wdata[6], bus_wdata[7]};
  end

  always_comb begin
    flag_nxt = flag;
    if (bus_we && bus_addr == A_REQH) flag_nxt[3:0] = {bus_wdata[4], bus_wdata[5], bus_wdata[6], bus_wdata[7]};
    if (bus_we && bus_addr == A_REQL) flag_nxt[6:4] = {bus_wdata[5], bus_wdata[6], bus_wdata[7]};
    if (ack && ack_idx < 3'(NSRC)) flag_nxt[ack_idx] = 1'b0;
    flag_nxt = flag_nxt | src_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= '0;
      en   <= '0;
    end else begin
      flag <= flag_nxt;
      en   <= en_nxt;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_ENH:   bus_rdata = {en[0], en[1], en[2], en[3], 4'b0};
      A_ENL:   bus_rdata = {en[4], en[5], en[6], 5'b0};
      A_REQH:  bus_rdata = {flag[0], flag[1], flag[2], flag[3], 4'b0};
      A_REQL:  bus_rdata = {flag[4], flag[5], flag[6], 5'b0};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign hit         = flag & en & {NSRC{master_en}};
  assign irq_pending = |hit;

  always_comb begin
    irq_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (hit[i]) irq_idx = 3'(i);
  end
endmodule

module irq_flag_ctrl_chk #(
  parameter logic [7:0] A_ENH  = 8'hE2,
  parameter logic [7:0] A_ENL  = 8'hE3,
  parameter logic [7:0] A_REQH = 8'hE4,
  parameter logic [7:0] A_REQL = 8'hE5
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_rdata,
  input logic [6:0] src_evt,
  input logic       master_en,
  input logic       ack,
  input logic [2:0] ack_idx,
  input logic       irq_pending,
  input logic [2:0] irq_idx,
  input logic [6:0] flag,
  input logic [6:0] en
);
  logic flag_wr;
  assign flag_wr = bus_we && (bus_addr == A_REQH || bus_addr == A_REQL);

  p_pad_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ENH || bus_addr == A_REQH) |-> bus_rdata[3:0] == 4'h0);

  p_pad_lo_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ENL || bus_addr == A_REQL) |-> bus_rdata[4:0] == 5'h0);

  p_evt_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != 7'h0) |=> ($past(src_evt) & ~flag) == 7'h0);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !flag_wr) |=> (flag & $past(flag)) == $past(flag));

  p_master_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq_pending);

  p_winner_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (flag[irq_idx] && en[irq_idx]));

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_idx < 3'd7 && !src_evt[ack_idx] && !flag_wr) |=> !flag[$past(ack_idx)]);

  p_evt_beats_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_idx < 3'd7 && src_evt[ack_idx]) |=> flag[$past(ack_idx)]);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
  .A_ENH(A_ENH), .A_ENL(A_ENL), .A_REQH(A_REQH), .A_REQL(A_REQL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .src_evt(src_evt), .master_en(master_en),
  .ack(ack), .ack_idx(ack_idx), .irq_pending(irq_pending),
  .irq_idx(irq_idx), .flag(flag), .en(en)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] src_evt = '0;
  logic       master_en = 1'b0;
  logic       ack = 1'b0;
  logic [2:0] ack_idx = '0;
  logic       irq_pending;
  logic [2:0] irq_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
    .master_en(master_en), .ack(ack), .ack_idx(ack_idx),
    .irq_pending(irq_pending), .irq_idx(irq_idx)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(logic [6:0] e);
    @(negedge clk); src_evt = e;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 enh", 8'hE2, 8'h00); rd_chk("R1 enl", 8'hE3, 8'h00);
    rd_chk("R1 reqh", 8'hE4, 8'h00); rd_chk("R1 reql", 8'hE5, 8'h00);
    check("R1 pending", irq_pending, 0);
  endtask

  task automatic t_enable_rw;
    wr(8'hE2, 8'hFF); rd_chk("R2/R4 enh all", 8'hE2, 8'hF0);
    wr(8'hE3, 8'hFF); rd_chk("R2/R4 enl all", 8'hE3, 8'hE0);
    wr(8'hE2, 8'hA5); rd_chk("R2 enh pattern", 8'hE2, 8'hA0);
    wr(8'hE3, 8'h40); rd_chk("R2 enl pattern", 8'hE3, 8'h40);
  endtask

  task automatic t_flag_rw;
    wr(8'hE4, 8'h5F); rd_chk("R3 reqh write", 8'hE4, 8'h50);
    wr(8'hE5, 8'hBF); rd_chk("R3 reql write", 8'hE5, 8'hA0);
    wr(8'hE4, 8'h00); rd_chk("R3 reqh clear", 8'hE4, 8'h00);
    wr(8'hE5, 8'h00); rd_chk("R3 reql clear", 8'hE5, 8'h00);
  endtask

  task automatic t_foreign_addr;
    wr(8'hE6, 8'hFF); wr(8'hE1, 8'hFF);
    rd_chk("R4 addr E6", 8'hE6, 8'h00); rd_chk("R4 addr E1", 8'hE1, 8'h00);
    rd_chk("R4 reqh untouched", 8'hE4, 8'h00);
    rd_chk("R4 enh untouched", 8'hE2, 8'hA0);
  endtask

  task automatic t_latch;
    pulse(7'b000_1000);
    rd_chk("R5 T1 latched", 8'hE4, 8'h10);
    repeat (5) @(negedge clk);
    rd_chk("R5 T1 sticky", 8'hE4, 8'h10);
    pulse(7'b100_0000);
    rd_chk("R5 BIT latched", 8'hE5, 8'h20);
    wr(8'hE4, 8'h00); wr(8'hE5, 8'h00);
  endtask

  task automatic t_pending;
    wr(8'hE2, 8'hF0); wr(8'hE3, 8'hE0);
    master_en = 1'b0;
    pulse(7'b000_0100);
    check("R6 masked by master", irq_pending, 0);
    master_en = 1'b1; #1;
    check("R6 pending", irq_pending, 1);
    check("R7 idx T0", irq_idx, 2);
    wr(8'hE2, 8'h00); #1;
    check("R6 enable blocks", irq_pending, 0);
    wr(8'hE4, 8'h00);
  endtask

  task automatic t_priority;
    wr(8'hE4, 8'hF0); wr(8'hE5, 8'hE0);
    for (int k = 0; k < 7; k++) begin
      logic [6:0] m;
      m = 7'h7F << k;
      wr(8'hE2, {m[0], m[1], m[2], m[3], 4'b0});
      wr(8'hE3, {m[4], m[5], m[6], 5'b0});
      #1;
      check("R7 priority pending", irq_pending, 1);
      check("R7 priority idx", irq_idx, k);
    end
    wr(8'hE2, 8'hF0); wr(8'hE3, 8'hE0);
    wr(8'hE4, 8'h00); #1;
    check("R7 low half winner ADC", irq_idx, 4);
  endtask

  task automatic t_ack;
    wr(8'hE4, 8'hF0); wr(8'hE5, 8'hE0);
    @(negedge clk); ack = 1'b1; ack_idx = 3'd2;
    @(negedge clk); ack = 1'b0;
    rd_chk("R8 ack T0 reqh", 8'hE4, 8'hD0);
    rd_chk("R8 ack T0 reql", 8'hE5, 8'hE0);
    @(negedge clk); ack = 1'b1; ack_idx = 3'd6;
    @(negedge clk); ack = 1'b0;
    rd_chk("R8 ack BIT reql", 8'hE5, 8'hC0);
    check("R8 winner after ack", irq_idx, 0);
  endtask

  task automatic t_collide;
    wr(8'hE4, 8'h00); wr(8'hE5, 8'h40);
    @(negedge clk); ack = 1'b1; ack_idx = 3'd5; src_evt = 7'b010_0000;
    @(negedge clk); ack = 1'b0; src_evt = '0;
    rd_chk("R9 evt beats ack", 8'hE5, 8'h40);
    @(negedge clk); bus_addr = 8'hE5; bus_wdata = 8'h00; bus_we = 1'b1; src_evt = 7'b001_0000;
    @(negedge clk); bus_we = 1'b0; src_evt = '0;
    rd_chk("R9 evt beats write", 8'hE5, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_rw();
    t_flag_rw();
    t_foreign_addr();
    t_latch();
    t_pending();
    t_priority();
    t_ack();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule